// File: doc/BRIEF.md
# BCD Decade Counter Stage

A four-bit synchronous counter that steps through the decimal digits 0 to 9 and then returns to 0. It is meant as one digit of a wider decimal counter. Each stage has a terminal-count output, and that output feeds the carry enable of the next stage. A ripple of digits is built from identical stages with no logic between them.

The register changes only on a rising clock edge, with one exception: the active-low clear acts at once and ignores the clock. An active-low load copies a four-bit value into the stage on the next edge. Counting needs both enables high: a local count enable and a chain enable. The terminal-count output is combinational. It depends on the chain enable and the held digit only, so a stage that is held at 9 by its local enable still signals carry.

Top module: `bcd_decade_counter`

## Requirements
- R1: While `clr_n` is low, `q` is 0 without waiting for a clock edge, whatever the levels of `load_n`, `cnt_en` and `chain_en`. `tc` is low during clear.
- R2: When `load_n` is low at a rising edge, `q` takes `din` on that edge, whatever the levels of `cnt_en` and `chain_en`.
- R3: When `load_n`, `cnt_en` and `chain_en` are all high at a rising edge and `q` is in 0..8, `q` becomes `q`+1.
- R4: When counting is enabled at a rising edge and `q` is 9, `q` becomes 0.
- R5: When `load_n` is high and either `cnt_en` or `chain_en` is low at a rising edge, `q` keeps its value.
- R6: `tc` is high exactly when `chain_en` is high and `q` equals 9 (binary 1001). `cnt_en` has no effect on `tc`.
- R7: A loaded value from 10 to 15 keeps `tc` low. The next enabled count after such a load sets `q` to 0.
- R8: Three stages can be chained, with each stage's `tc` driving the next stage's `chain_en` and every `cnt_en` held high. The chain then counts modulo 1000, with the first stage as the units digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Local count enable, active high |
| chain_en | input | 1 | Chain count enable, active high; also qualifies `tc` |
| din | input | 4 | Value to load |
| q | output | 4 | Current digit |
| tc | output | 1 | Terminal count (carry to the next stage) |

## Verification
The state sits directly on `q`, so a wrong next-state value shows on the port one edge after it is made. A wrong terminal-count decode shows at once on `tc` and is not delayed by a register. The bench loads every one of the sixteen codes under all four enable combinations, so an error in the increment, the wrap, the illegal-code recovery or the enable qualification shows within one or two cycles. A carry fault in a chain hides until a digit rolls over, so the three-stage run covers more than a full 000..999 period.

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter #(
  parameter int W = 4,
  parameter int LAST = 9
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         cnt_en,
  input  logic         chain_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] TOP = W'(LAST);

  logic step;
  logic [W-1:0] nxt;

  assign step = cnt_en & chain_en;
  assign nxt  = (q >= TOP) ? '0 : q + 1'b1;
  assign tc   = chain_en & (q == TOP);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)      q <= '0;
    else if (!load_n) q <= din;
    else if (step)    q <= nxt;
  end
endmodule

module bcd_decade_counter_chk (
  input logic       clk,
  input logic       clr_n,
  input logic       load_n,
  input logic       cnt_en,
  input logic       chain_en,
  input logic [3:0] din,
  input logic [3:0] q,
  input logic       tc
);
  p_clear_r1: assert property (@(negedge clk) !clr_n |-> (q == 4'd0 && !tc));
  p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));
  p_incr_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en && chain_en && q < 4'd9) |=> q == $past(q) + 4'd1);
  p_wrap_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en && chain_en && q >= 4'd9) |=> q == 4'd0);
  p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(cnt_en && chain_en)) |=> $stable(q));
  p_tc_r6: assert property (@(negedge clk) disable iff (!clr_n)
    tc |-> (chain_en && q == 4'd9));
endmodule

bind bcd_decade_counter bcd_decade_counter_chk u_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
  .chain_en(chain_en), .din(din), .q(q), .tc(tc)
);

// File: tb/bcd_decade_counter_test.sv
module bcd_decade_counter_test;
  logic clk = 1'b0;
  logic clr_n = 1'b0, load_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] q;
  logic tc;

  logic ch_clr_n = 1'b0;
  logic [3:0] q0, q1, q2;
  logic tc0, tc1, tc2;

  int vectors = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bcd_decade_counter uut (.clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .din(din), .q(q), .tc(tc));

  bcd_decade_counter s0 (.clk(clk), .clr_n(ch_clr_n), .load_n(1'b1), .cnt_en(1'b1),
    .chain_en(1'b1), .din(4'd0), .q(q0), .tc(tc0));
  bcd_decade_counter s1 (.clk(clk), .clr_n(ch_clr_n), .load_n(1'b1), .cnt_en(1'b1),
    .chain_en(tc0), .din(4'd0), .q(q1), .tc(tc1));
  bcd_decade_counter s2 (.clk(clk), .clr_n(ch_clr_n), .load_n(1'b1), .cnt_en(1'b1),
    .chain_en(tc1), .din(4'd0), .q(q2), .tc(tc2));

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_then_sample();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int exp;
    // R1: reset state with load and enables active
    load_n = 1'b0; din = 4'd9; cnt_en = 1'b1; chain_en = 1'b1;
    edge_then_sample();
    edge_then_sample();
    check("R1 q in clear", q, 0);
    check("R1 tc in clear", tc, 0);
    clr_n = 1'b1; load_n = 1'b1;

    for (int v = 0; v < 16; v++) begin
      for (int e = 0; e < 4; e++) begin
        load_n = 1'b0; din = 4'(v); cnt_en = e[0]; chain_en = e[1];
        edge_then_sample();
        check("R2 load", q, v);
        load_n = 1'b1;
        #1;
        exp = (e[1] && v == 9) ? 1 : 0;
        check(v > 9 ? "R7 tc low on illegal" : "R6 tc decode", tc, exp);
        edge_then_sample();
        if (e == 3) begin
          if (v < 9) begin
            exp = v + 1;
            check("R3 increment", q, exp);
          end else if (v == 9) begin
            exp = 0;
            check("R4 wrap", q, exp);
          end else begin
            exp = 0;
            check("R7 illegal recovers", q, exp);
          end
        end else begin
          exp = v;
          check("R5 hold", q, exp);
        end
      end
    end

    // R6: a stage held at 9 by cnt_en low still raises tc
    load_n = 1'b0; din = 4'd9; edge_then_sample();
    load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b1; #1;
    check("R6 tc with cnt_en low", tc, 1);
    chain_en = 1'b0; #1;
    check("R6 tc gated by chain_en", tc, 0);

    // R1: asynchronous clear between edges
    load_n = 1'b0; din = 4'd6; edge_then_sample();
    load_n = 1'b1;
    #3 clr_n = 1'b0;
    #2;
    check("R1 async clear", q, 0);
    edge_then_sample();
    clr_n = 1'b1;

    // R8: three stage chain modulo 1000
    ch_clr_n = 1'b1;
    for (int n = 1; n <= 1205; n++) begin
      edge_then_sample();
      check("R8 chain value", 100 * q2 + 10 * q1 + q0, n % 1000);
      if (n % 1000 == 999) check("R8 chain carry", tc2, 1);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule